// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block sits in the feedback path of a frequency synthesizer. It divides a fast feedback clock so that the average ratio between input clocks and output pulses is INT + FRAC/MOD. The core is a down-counter whose reload value changes every output period. A third-order cascade of three modulo-MOD accumulators (a MASH structure) produces a small signed offset that is added to INT at each reload. The modulus MOD is programmable and does not have to be a power of two.

Each output period ends with a single-clock pulse to the phase detector. A setting that is out of range raises an error flag. While the flag is up, the divider keeps running on the last legal setting. A setting is adopted only on the clock edge that ends a period, so no period is ever cut short. When the integer-mode flag is set and FRAC is zero, the accumulators stay at zero and every period is exactly INT clocks long.

Top module: `fracn_fb_divider`

## Requirements
- R1: Over K consecutive output periods of one fixed legal setting, the total clock count differs from K·INT + K·FRAC/MOD by at most 3 clocks, for any MOD from 2 to 4095.
- R2: The length of each single period is INT plus a signed offset in the range −3 to +4. The offset is c1 + (c2 − c2') + (c3 − 2·c3' + c3''), built from the carries of three cascaded modulo-MOD accumulators, where a prime marks the previous period's carry. When FRAC is non-zero, the period length varies.
- R3: When `int_mode` is 1 and FRAC is 0, every period is exactly INT clocks long.
- R4: `div_pulse` is high for exactly one clock per output period, on the clock that follows the period's terminal count.
- R5: `cfg_err` rises one clock after the inputs become illegal and falls one clock after they become legal again. The inputs are illegal when any of these holds: INT is below 23 with `presc_sel` = 0, INT is below 75 with `presc_sel` = 1, MOD is below 2, or FRAC is not below MOD. The values 23 and 75 themselves are legal.
- R6: While the inputs are illegal, the divider keeps dividing with the last legal setting it adopted.
- R7: A legal setting is sampled on the clock edge that ends a period, and it governs the period that starts at that edge. A change made in the middle of a period does not alter the period under way.
- R8: During reset, `div_pulse` and `cfg_err` are low and the accumulators are cleared.
- R9: A change to INT, FRAC or MOD restarts the accumulators from zero, so the offset stays in range even when the new MOD is smaller than the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast feedback clock being divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_word | input | 16 | Integer part of the ratio |
| frac_word | input | 12 | Fraction numerator |
| mod_word | input | 12 | Fraction modulus |
| presc_sel | input | 1 | Prescaler mode: 0 = small (minimum INT 23), 1 = large (minimum INT 75) |
| int_mode | input | 1 | Forces pure integer division when FRAC is 0 |
| div_pulse | output | 1 | One-clock pulse at the end of each output period |
| cfg_err | output | 1 | Registered flag for an illegal setting |

## Verification
The error flag is due one clock after an input change. The bench changes inputs on a falling edge, lets one rising edge pass, and samples the flag on the next falling edge. A new setting first shows up in the period that begins at the next terminal-count edge. For that reason the bench changes settings right after a pulse is seen, expects the period already loaded to keep its old length, and expects the new length from the following pulse onward. Period lengths are pulse-to-pulse distances read from a rising-edge cycle counter at falling edges. Each pulse is also checked to be low again at the next falling edge.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
   // order of the noise-shaping cascade; the carry combination is written for three
   localparam int MASH_ORDER = 3;
   // signed per-period offset, range -3..+4
   typedef logic signed [3:0] ofs_t;
   typedef enum logic {PRESC_SMALL = 1'b0, PRESC_LARGE = 1'b1} presc_e;
endpackage

// File: rtl/fnd_cfg_gate.sv
module fnd_cfg_gate
   import fnd_pkg::*;
#(
   parameter int INT_W   = 16,
   parameter int MOD_W   = 12,
   parameter int MIN_SM  = 23,
   parameter int MIN_LG  = 75,
   parameter int RST_INT = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boundary,
   input  logic [INT_W-1:0] int_in,
   input  logic [MOD_W-1:0] frac_in,
   input  logic [MOD_W-1:0] mod_in,
   input  logic             presc_in,
   input  logic             intm_in,
   output logic [INT_W-1:0] sel_int,
   output logic [MOD_W-1:0] sel_frac,
   output logic [MOD_W-1:0] sel_mod,
   output logic             sel_intm,
   output logic [INT_W-1:0] act_int,
   output logic             restart,
   output logic             err_q
);
   presc_e           mode;
   logic [INT_W-1:0] min_int;
   logic             legal;
   logic [MOD_W-1:0] act_frac, act_mod;
   logic             act_intm;

   assign mode    = presc_e'(presc_in);
   assign min_int = (mode == PRESC_LARGE) ? INT_W'(MIN_LG) : INT_W'(MIN_SM);
   assign legal   = (int_in >= min_int) && (mod_in >= MOD_W'(2)) && (frac_in < mod_in);

   always_comb begin
      if (legal) begin
         sel_int  = int_in;
         sel_frac = frac_in;
         sel_mod  = mod_in;
         sel_intm = intm_in;
      end else begin
         sel_int  = act_int;
         sel_frac = act_frac;
         sel_mod  = act_mod;
         sel_intm = act_intm;
      end
   end

   assign restart = legal && ({int_in, frac_in, mod_in} != {act_int, act_frac, act_mod});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_int  <= INT_W'(RST_INT);
         act_frac <= '0;
         act_mod  <= MOD_W'(2);
         act_intm <= 1'b1;
         err_q    <= 1'b0;
      end else begin
         err_q <= !legal;
         if (boundary) begin
            act_int  <= sel_int;
            act_frac <= sel_frac;
            act_mod  <= sel_mod;
            act_intm <= sel_intm;
         end
      end
   end
endmodule

// File: rtl/fnd_mash.sv
module fnd_mash
   import fnd_pkg::*;
#(
   parameter int MOD_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             restart,
   input  logic             hold,
   input  logic [MOD_W-1:0] frac,
   input  logic [MOD_W-1:0] modu,
   output ofs_t             ofs
);
   localparam int ORDER = MASH_ORDER;

   logic [MOD_W-1:0] acc_q  [ORDER];
   logic [MOD_W-1:0] acc_nx [ORDER];
   logic [MOD_W-1:0] addend [ORDER];
   logic             cy     [ORDER];

   for (genvar k = 0; k < ORDER; k++) begin : g_stage
      logic [MOD_W:0] base, sum;
      if (k == 0) begin : g_head
         assign addend[k] = frac;
      end else begin : g_chain
         assign addend[k] = acc_nx[k-1];
      end
      always_comb begin
         base  = restart ? '0 : {1'b0, acc_q[k]};
         sum   = base + {1'b0, addend[k]};
         cy[k] = !hold && (sum >= {1'b0, modu});
         if (hold)
            acc_nx[k] = '0;
         else if (cy[k])
            acc_nx[k] = MOD_W'(sum - {1'b0, modu});
         else
            acc_nx[k] = sum[MOD_W-1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            acc_q[k] <= '0;
         else if (step)
            acc_q[k] <= acc_nx[k];
      end
   end

   // carry history used by the differentiating combination
   logic c2d, c3d, c3dd;
   logic clr;
   logic c2e, c3e, c3ee;
   assign clr  = restart | hold;
   assign c2e  = !clr && c2d;
   assign c3e  = !clr && c3d;
   assign c3ee = !clr && c3dd;

   always_comb begin
      ofs = $signed({3'b000, cy[0]})
          + $signed({3'b000, cy[1]}) - $signed({3'b000, c2e})
          + $signed({3'b000, cy[2]}) - $signed({2'b00, c3e, 1'b0}) + $signed({3'b000, c3ee});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c2d  <= 1'b0;
         c3d  <= 1'b0;
         c3dd <= 1'b0;
      end else if (step) begin
         c2d  <= cy[1];
         c3d  <= cy[2];
         c3dd <= c3e;
      end
   end
endmodule

// File: rtl/fnd_ncount.sv
module fnd_ncount #(
   parameter int CW = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] load_val,
   output logic          terminal,
   output logic          pulse
);
   logic [CW-1:0] cnt;
   assign terminal = (cnt == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= CW'(1);
         pulse <= 1'b0;
      end else begin
         pulse <= terminal;
         cnt   <= terminal ? load_val : cnt - CW'(1);
      end
   end
endmodule

// File: rtl/fracn_fb_divider.sv
module fracn_fb_divider
   import fnd_pkg::*;
#(
   parameter int INT_W   = 16,
   parameter int MOD_W   = 12,
   parameter int MIN_SM  = 23,
   parameter int MIN_LG  = 75,
   parameter int RST_INT = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INT_W-1:0] int_word,
   input  logic [MOD_W-1:0] frac_word,
   input  logic [MOD_W-1:0] mod_word,
   input  logic             presc_sel,
   input  logic             int_mode,
   output logic             div_pulse,
   output logic             cfg_err
);
   localparam int CW = INT_W + 1;

   if (MIN_SM < 5 || MIN_LG < 5) begin : g_bad_min
      $error("minimum INT must exceed the largest negative offset plus one");
   end
   if (RST_INT < MIN_SM || RST_INT >= (1 << INT_W)) begin : g_bad_rst
      $error("reset INT out of range");
   end
   if (MOD_W < 2 || INT_W < 8) begin : g_bad_w
      $error("word widths too small");
   end
   if (MASH_ORDER != 3) begin : g_bad_order
      $error("carry combination is third order only");
   end

   logic [INT_W-1:0] sel_int, act_int;
   logic [MOD_W-1:0] sel_frac, sel_mod;
   logic             sel_intm, restart, hold, terminal;
   ofs_t             ofs;
   logic signed [CW:0] n_wide;
   logic [CW-1:0]    load_val;

   fnd_cfg_gate #(
      .INT_W(INT_W), .MOD_W(MOD_W), .MIN_SM(MIN_SM), .MIN_LG(MIN_LG), .RST_INT(RST_INT)
   ) u_gate (
      .clk(clk), .rst_n(rst_n), .boundary(terminal),
      .int_in(int_word), .frac_in(frac_word), .mod_in(mod_word),
      .presc_in(presc_sel), .intm_in(int_mode),
      .sel_int(sel_int), .sel_frac(sel_frac), .sel_mod(sel_mod), .sel_intm(sel_intm),
      .act_int(act_int), .restart(restart), .err_q(cfg_err)
   );

   assign hold = sel_intm && (sel_frac == '0);

   fnd_mash #(.MOD_W(MOD_W)) u_mash (
      .clk(clk), .rst_n(rst_n), .step(terminal), .restart(restart), .hold(hold),
      .frac(sel_frac), .modu(sel_mod), .ofs(ofs)
   );

   assign n_wide   = $signed({2'b00, sel_int}) + $signed({{(CW-3){ofs[3]}}, ofs});
   assign load_val = n_wide[CW-1:0];

   fnd_ncount #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load_val(load_val), .terminal(terminal), .pulse(div_pulse)
   );
endmodule

// File: rtl/fnd_checker.sv
module fnd_checker #(
   parameter int INT_W  = 16,
   parameter int MOD_W  = 12,
   parameter int MIN_SM = 23,
   parameter int MIN_LG = 75
) (
   input logic             clk,
   input logic             rst_n,
   input logic [INT_W-1:0] int_word,
   input logic [MOD_W-1:0] frac_word,
   input logic [MOD_W-1:0] mod_word,
   input logic             presc_sel,
   input logic             div_pulse,
   input logic             cfg_err,
   input logic             terminal,
   input logic             hold,
   input logic signed [3:0] ofs,
   input logic [INT_W-1:0] act_int
);
   logic armed;
   logic bad;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end
   assign bad = (int_word < (presc_sel ? INT_W'(MIN_LG) : INT_W'(MIN_SM)))
             || (mod_word < MOD_W'(2)) || (frac_word >= mod_word);

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse); // R4
   AST_OFS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      terminal |-> (ofs >= -4'sd3) && (ofs <= 4'sd4)); // R2
   AST_INTMODE_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
      (terminal && hold) |-> (ofs == 4'sd0)); // R3
   AST_ERR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (cfg_err == $past(bad))); // R5
   AST_CFG_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !$past(terminal)) |-> $stable(act_int)); // R7
   AST_PULSE_AFTER_TC: assert property (@(posedge clk) disable iff (!rst_n)
      terminal |=> div_pulse); // R4
endmodule

bind fracn_fb_divider fnd_checker #(
   .INT_W(INT_W), .MOD_W(MOD_W), .MIN_SM(MIN_SM), .MIN_LG(MIN_LG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .int_word(int_word), .frac_word(frac_word),
   .mod_word(mod_word), .presc_sel(presc_sel), .div_pulse(div_pulse),
   .cfg_err(cfg_err), .terminal(terminal), .hold(hold), .ofs(ofs), .act_int(act_int)
);

// File: tb/fracn_fb_divider_test.sv
module fracn_fb_divider_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] int_word = 16'd40;
   logic [11:0] frac_word = 12'd0;
   logic [11:0] mod_word = 12'd2;
   logic        presc_sel = 1'b0;
   logic        int_mode = 1'b1;
   logic        div_pulse, cfg_err;

   int    checks = 0;
   int    errors = 0;
   longint cyc = 0;
   bit    done = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   fracn_fb_divider uut (
      .clk(clk), .rst_n(rst_n), .int_word(int_word), .frac_word(frac_word),
      .mod_word(mod_word), .presc_sel(presc_sel), .int_mode(int_mode),
      .div_pulse(div_pulse), .cfg_err(cfg_err)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic apply(input int iv, input int fv, input int mv, input bit ps, input bit im);
      int_word  = 16'(iv);
      frac_word = 12'(fv);
      mod_word  = 12'(mv);
      presc_sel = ps;
      int_mode  = im;
   endtask

   // waits for a pulse, returns its cycle stamp, then checks it lasted one clock
   task automatic next_pulse(output longint t);
      int guard = 0;
      do begin
         @(negedge clk);
         guard++;
      end while (!div_pulse && guard < 70000);
      t = cyc;
      @(negedge clk);
      chk(!div_pulse, "R4 pulse width", longint'(div_pulse), 0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(!div_pulse, "R8 pulse in reset", longint'(div_pulse), 0);
      chk(!cfg_err, "R8 error in reset", longint'(cfg_err), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_integer(input int iv);
      longint t0, t1;
      apply(iv, 0, 2, 1'b0, 1'b1);
      next_pulse(t0);
      for (int i = 0; i < 5; i++) begin
         next_pulse(t1);
         chk(t1 - t0 == iv, "R3 integer period", t1 - t0, iv);
         t0 = t1;
      end
   endtask

   task automatic t_fraction(input int iv, input int fv, input int mv, input bit ps, input int k);
      longint t0, tp, t1, diff;
      bit varied = 1'b0;
      apply(iv, fv, mv, ps, 1'b0);
      next_pulse(t0);
      tp = t0;
      t1 = t0;
      for (int i = 0; i < k; i++) begin
         next_pulse(t1);
         chk((t1 - tp >= iv - 3) && (t1 - tp <= iv + 4), "R2 period range", t1 - tp, iv);
         if (t1 - tp != iv) varied = 1'b1;
         tp = t1;
      end
      diff = (t1 - t0) * mv - (longint'(k) * iv * mv + longint'(k) * fv);
      chk((diff <= 3 * mv) && (diff >= -3 * mv), "R1 average ratio",
          t1 - t0, longint'(k) * iv + (longint'(k) * fv) / mv);
      if (fv != 0) chk(varied, "R2 ratio varies", longint'(varied), 1);
   endtask

   task automatic t_boundary();
      longint a, b, c, d, e;
      t_integer(40);
      next_pulse(a);
      apply(60, 0, 2, 1'b0, 1'b1);
      next_pulse(b);
      chk(b - a == 40, "R7 loaded period kept", b - a, 40);
      next_pulse(c);
      chk(c - b == 60, "R7 new period", c - b, 60);
      repeat (10) @(negedge clk);
      apply(50, 0, 2, 1'b0, 1'b1);
      next_pulse(d);
      chk(d - c == 60, "R7 mid-period change ignored", d - c, 60);
      next_pulse(e);
      chk(e - d == 50, "R7 change at boundary", e - d, 50);
   endtask

   task automatic err_step(input int iv, input int fv, input int mv, input bit ps, input bit exp);
      apply(iv, fv, mv, ps, 1'b1);
      @(negedge clk);
      chk(cfg_err == exp, "R5 error flag", longint'(cfg_err), longint'(exp));
   endtask

   task automatic t_error();
      longint a, b, c;
      t_integer(40);
      err_step(22, 0, 2, 1'b0, 1'b1);
      next_pulse(a);
      next_pulse(b);
      next_pulse(c);
      chk(c - b == 40, "R6 last legal kept", c - b, 40);
      chk(cfg_err, "R5 flag stays up", longint'(cfg_err), 1);
      err_step(23, 0, 2, 1'b0, 1'b0);
      err_step(74, 0, 2, 1'b1, 1'b1);
      err_step(75, 0, 2, 1'b1, 1'b0);
      err_step(40, 0, 1, 1'b0, 1'b1);
      err_step(40, 5, 5, 1'b0, 1'b1);
      err_step(40, 4, 5, 1'b0, 1'b0);
   endtask

   initial begin
      t_reset();
      t_integer(40);
      t_integer(23);
      t_fraction(30, 1, 4, 1'b0, 16);
      t_fraction(100, 333, 1000, 1'b0, 200);  // R9 restart on change
      t_fraction(30, 3, 4, 1'b0, 16);         // R9 smaller modulus after larger
      t_fraction(23, 4094, 4095, 1'b0, 100);
      t_fraction(75, 7, 9, 1'b1, 27);
      t_boundary();
      t_error();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      wait (cyc > 190000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule